// File: doc/BRIEF.md
# Two-Word-Burst Split-Port Synchronous SRAM

This block is a synthesizable model of a static memory with a read data port and a separate write data port. Both ports can start a burst in the same clock cycle, so the data buses never turn around. One address bus is shared at double data rate. The read address is taken on the rising edge of the true input clock. The write address is taken on the rising edge of the complemented input clock, half a cycle later. Every access moves two words, and these two words sit in the two positions of one burst slot.

Write data comes in one word per half cycle, each word with its own active-low byte-lane enables. The write is held in an internal buffer until the next true-clock edge commits it to the array. A read that reaches the array while that buffer is still pending gets the buffered bytes. Read data leaves on an output clock pair. The first word appears one and a half cycles after the read command and the second word half a cycle later. A valid flag and two echo clocks travel with the data. If both output clocks are held high, the input clock pair times the output instead.

Top module: `qb2_sram`

## Requirements
- R1: When `r_n` is low at a rising edge of `k_clk`, the two words stored at slot `sa` come out on `q`. Word 0 is driven from the rise of the complemented output clock 1.5 cycles later. Word 1 is driven from the rise of the true output clock 2 cycles later. `q_vld` is high for both beats.
- R2: When `w_n` is low at a rising edge of `k_clk`, that edge captures word 0 from `d` together with its lane enables `bw_n`. The next rising edge of `kn_clk` captures the slot address from `sa`, word 1 from `d` and word 1's lane enables. The two words are stored at positions 0 and 1 of that slot.
- R3: `bw_n[i]` low enables byte lane i, which is bits 9*i+8 down to 9*i of a word. A lane whose bit is high keeps its stored byte, and this applies to each beat separately.
- R4: A read and a write issued in the same cycle to different slots both complete, and neither disturbs the other.
- R5: A read must return the newly written bytes of a write to the same slot, merged with the old contents of the disabled lanes. This holds when the write was issued in the same cycle as the read or in the cycle before it.
- R6: In a cycle with `r_n` high, both output beat registers keep their previous value and `q_vld` stays low. In a cycle with `w_n` high, the array is left unchanged.
- R7: When `c_clk` and `cn_clk` are both held high, `k_clk` and `kn_clk` take their place in timing the read beats, with the same latency as R1.
- R8: `cq` follows the true output clock in use and `cq_n` follows the complemented one. `cq` is therefore low during the word-0 beat and high during the word-1 beat.
- R9: While `rst_n` is low, `q_vld` is low and `q` is zero.
- R10: Reads issued in consecutive cycles produce an unbroken stream of beats, in the order the reads were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | True input clock |
| kn_clk | input | 1 | Complemented input clock |
| c_clk | input | 1 | True output clock |
| cn_clk | input | 1 | Complemented output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| r_n | input | 1 | Read strobe, active low |
| w_n | input | 1 | Write strobe, active low |
| sa | input | AW | Shared slot address: read on `k_clk` rise, write on `kn_clk` rise |
| bw_n | input | DW/9 | Active-low byte-lane enables for the current write beat |
| d | input | DW | Write data, one word per half cycle |
| q | output | DW | Read data, one word per half cycle |
| q_vld | output | 1 | High during both beats of a read burst |
| cq | output | 1 | Echo of the true output clock in use |
| cq_n | output | 1 | Echo of the complemented output clock in use |

## Verification
The bench builds the block with a 36-bit word and a 4-bit slot address. The wide word gives four byte lanes, so alternating and split enable patterns can be applied on the two beats separately, including a partial write that overlaps a same-cycle read through the write buffer. With only sixteen slots the bench keeps a full reference copy of the array, and it reads every slot it has written. The bench also switches the output clocks between running with the input clocks and being held high, which covers both timing sources.

// File: rtl/qb2_pkg.sv
package qb2_pkg;
    // bits guarded by one byte-lane enable
    localparam int LANE_BITS = 9;

    function automatic int lane_count(input int word_bits);
        return word_bits / LANE_BITS;
    endfunction
endpackage

// File: rtl/qb2_clk_sel.sv
module qb2_clk_sel (
    input  logic k_clk,
    input  logic kn_clk,
    input  logic c_clk,
    input  logic cn_clk,
    output logic oc_clk,
    output logic ocn_clk
);
    logic fall_back;

    // both output clocks parked high: time the output from the input pair
    assign fall_back = c_clk & cn_clk;
    assign oc_clk    = fall_back ? k_clk  : c_clk;
    assign ocn_clk   = fall_back ? kn_clk : cn_clk;
endmodule

// File: rtl/qb2_wr_capture.sv
module qb2_wr_capture #(
    parameter  int DW = 36,
    parameter  int AW = 8,
    localparam int NL = qb2_pkg::lane_count(DW)
) (
    input  logic          k_clk,
    input  logic          kn_clk,
    input  logic          rst_n,
    input  logic          w_n,
    input  logic [AW-1:0] sa,
    input  logic [DW-1:0] d,
    input  logic [NL-1:0] bw_n,
    output logic          wb_vld,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_d0,
    output logic [DW-1:0] wb_d1,
    output logic [NL-1:0] wb_en0,
    output logic [NL-1:0] wb_en1
);
    typedef struct packed {
        logic          cmd;
        logic [DW-1:0] d0;
        logic [NL-1:0] en0;
    } head_t;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic [NL-1:0] en0;
        logic [NL-1:0] en1;
    } wbuf_t;

    head_t head_d, head_q;
    wbuf_t wbuf_d, wbuf_q;

    // next values for both half-cycle stages
    always_comb begin
        head_d     = head_q;
        head_d.cmd = ~w_n;
        if (!w_n) begin
            head_d.d0  = d;
            head_d.en0 = ~bw_n;
        end

        wbuf_d     = wbuf_q;
        wbuf_d.vld = head_q.cmd;
        if (head_q.cmd) begin
            wbuf_d.addr = sa;
            wbuf_d.d0   = head_q.d0;
            wbuf_d.d1   = d;
            wbuf_d.en0  = head_q.en0;
            wbuf_d.en1  = ~bw_n;
        end
    end

    // command and first beat on the true edge
    always_ff @(posedge k_clk or negedge rst_n) begin
        if (!rst_n) head_q <= '0;
        else        head_q <= head_d;
    end

    // address and second beat on the complemented edge
    always_ff @(posedge kn_clk or negedge rst_n) begin
        if (!rst_n) wbuf_q <= '0;
        else        wbuf_q <= wbuf_d;
    end

    assign wb_vld  = wbuf_q.vld;
    assign wb_addr = wbuf_q.addr;
    assign wb_d0   = wbuf_q.d0;
    assign wb_d1   = wbuf_q.d1;
    assign wb_en0  = wbuf_q.en0;
    assign wb_en1  = wbuf_q.en1;
endmodule

// File: rtl/qb2_array.sv
module qb2_array #(
    parameter  int DW = 36,
    parameter  int AW = 8,
    localparam int NL    = qb2_pkg::lane_count(DW),
    localparam int LB    = qb2_pkg::LANE_BITS,
    localparam int DEPTH = 1 << AW
) (
    input  logic          k_clk,
    input  logic          rst_n,
    input  logic          r_n,
    input  logic [AW-1:0] sa,
    input  logic          wb_vld,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_d0,
    input  logic [DW-1:0] wb_d1,
    input  logic [NL-1:0] wb_en0,
    input  logic [NL-1:0] wb_en1,
    output logic          rs_vld,
    output logic [DW-1:0] rs_d0,
    output logic [DW-1:0] rs_d1
);
    typedef struct packed {
        logic          s1_vld;
        logic [AW-1:0] s1_addr;
        logic          s2_vld;
        logic [DW-1:0] s2_d0;
        logic [DW-1:0] s2_d1;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    logic [DW-1:0] mem_lo [DEPTH];
    logic [DW-1:0] mem_hi [DEPTH];
    logic          fwd_hit;
    logic [DW-1:0] merged0, merged1;

    // array word merged with any still-buffered bytes of the same slot
    always_comb begin
        fwd_hit = wb_vld && (wb_addr == rd_q.s1_addr);
        merged0 = mem_lo[rd_q.s1_addr];
        merged1 = mem_hi[rd_q.s1_addr];
        for (int l = 0; l < NL; l++) begin
            if (fwd_hit && wb_en0[l]) merged0[l*LB +: LB] = wb_d0[l*LB +: LB];
            if (fwd_hit && wb_en1[l]) merged1[l*LB +: LB] = wb_d1[l*LB +: LB];
        end
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.s1_vld = ~r_n;
        if (!r_n) rd_d.s1_addr = sa;
        rd_d.s2_vld = rd_q.s1_vld;
        if (rd_q.s1_vld) begin
            rd_d.s2_d0 = merged0;
            rd_d.s2_d1 = merged1;
        end
    end

    always_ff @(posedge k_clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // commit the buffered burst lane by lane
    always_ff @(posedge k_clk) begin
        if (wb_vld) begin
            for (int l = 0; l < NL; l++) begin
                if (wb_en0[l]) mem_lo[wb_addr][l*LB +: LB] <= wb_d0[l*LB +: LB];
                if (wb_en1[l]) mem_hi[wb_addr][l*LB +: LB] <= wb_d1[l*LB +: LB];
            end
        end
    end

    assign rs_vld = rd_q.s2_vld;
    assign rs_d0  = rd_q.s2_d0;
    assign rs_d1  = rd_q.s2_d1;
endmodule

// File: rtl/qb2_rd_out.sv
module qb2_rd_out #(
    parameter int DW = 36
) (
    input  logic          oc_clk,
    input  logic          ocn_clk,
    input  logic          rst_n,
    input  logic          rs_vld,
    input  logic [DW-1:0] rs_d0,
    input  logic [DW-1:0] rs_d1,
    output logic [DW-1:0] q,
    output logic          q_vld
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } beat_t;

    beat_t lo_d, lo_q, hi_d, hi_q;

    always_comb begin
        lo_d     = lo_q;
        lo_d.vld = rs_vld;
        if (rs_vld) lo_d.dat = rs_d0;

        hi_d     = hi_q;
        hi_d.vld = rs_vld;
        if (rs_vld) hi_d.dat = rs_d1;
    end

    // word 0 launched by the complemented output edge
    always_ff @(posedge ocn_clk or negedge rst_n) begin
        if (!rst_n) lo_q <= '0;
        else        lo_q <= lo_d;
    end

    // word 1 launched by the true output edge
    always_ff @(posedge oc_clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
    end

    assign q     = oc_clk ? hi_q.dat : lo_q.dat;
    assign q_vld = oc_clk ? hi_q.vld : lo_q.vld;
endmodule

// File: rtl/qb2_sram.sv
module qb2_sram #(
    parameter  int DW = 36,
    parameter  int AW = 8,
    localparam int NL = qb2_pkg::lane_count(DW)
) (
    input  logic          k_clk,
    input  logic          kn_clk,
    input  logic          c_clk,
    input  logic          cn_clk,
    input  logic          rst_n,
    input  logic          r_n,
    input  logic          w_n,
    input  logic [AW-1:0] sa,
    input  logic [NL-1:0] bw_n,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q,
    output logic          q_vld,
    output logic          cq,
    output logic          cq_n
);
    logic          oc_clk, ocn_clk;
    logic          wb_vld;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_d0, wb_d1;
    logic [NL-1:0] wb_en0, wb_en1;
    logic          rs_vld;
    logic [DW-1:0] rs_d0, rs_d1;

    qb2_clk_sel u_clk_sel (
        .k_clk  (k_clk),
        .kn_clk (kn_clk),
        .c_clk  (c_clk),
        .cn_clk (cn_clk),
        .oc_clk (oc_clk),
        .ocn_clk(ocn_clk)
    );

    qb2_wr_capture #(.DW(DW), .AW(AW)) u_wr_capture (
        .k_clk  (k_clk),
        .kn_clk (kn_clk),
        .rst_n  (rst_n),
        .w_n    (w_n),
        .sa     (sa),
        .d      (d),
        .bw_n   (bw_n),
        .wb_vld (wb_vld),
        .wb_addr(wb_addr),
        .wb_d0  (wb_d0),
        .wb_d1  (wb_d1),
        .wb_en0 (wb_en0),
        .wb_en1 (wb_en1)
    );

    qb2_array #(.DW(DW), .AW(AW)) u_array (
        .k_clk  (k_clk),
        .rst_n  (rst_n),
        .r_n    (r_n),
        .sa     (sa),
        .wb_vld (wb_vld),
        .wb_addr(wb_addr),
        .wb_d0  (wb_d0),
        .wb_d1  (wb_d1),
        .wb_en0 (wb_en0),
        .wb_en1 (wb_en1),
        .rs_vld (rs_vld),
        .rs_d0  (rs_d0),
        .rs_d1  (rs_d1)
    );

    qb2_rd_out #(.DW(DW)) u_rd_out (
        .oc_clk (oc_clk),
        .ocn_clk(ocn_clk),
        .rst_n  (rst_n),
        .rs_vld (rs_vld),
        .rs_d0  (rs_d0),
        .rs_d1  (rs_d1),
        .q      (q),
        .q_vld  (q_vld)
    );

    assign cq   = oc_clk;
    assign cq_n = ocn_clk;
endmodule

// File: rtl/qb2_sram_chk.sv
module qb2_sram_chk #(
    parameter int DW = 36
) (
    input logic          k_clk,
    input logic          rst_n,
    input logic          r_n,
    input logic          w_n,
    input logic          wb_vld,
    input logic [DW-1:0] q,
    input logic          q_vld,
    input logic          cq,
    input logic          cq_n
);
    logic [1:0] seen;

    always_ff @(posedge k_clk or negedge rst_n) begin
        if (!rst_n)          seen <= '0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // R1
    rd_latency_chk: assert property (@(posedge k_clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (q_vld == !$past(r_n, 2)));

    // R6
    idle_hold_chk: assert property (@(posedge k_clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(r_n, 2)) |-> $stable(q));

    // R2
    wr_commit_chk: assert property (@(posedge k_clk) disable iff (!rst_n)
        (seen >= 2'd1 && wb_vld) |-> !$past(w_n));

    // R8
    echo_lo_chk: assert property (@(posedge k_clk) disable iff (!rst_n)
        (!cq && cq_n));

    // R8
    echo_hi_chk: assert property (@(negedge k_clk) disable iff (!rst_n)
        (cq && !cq_n));
endmodule

bind qb2_sram qb2_sram_chk #(.DW(DW)) u_chk (
    .k_clk (k_clk),
    .rst_n (rst_n),
    .r_n   (r_n),
    .w_n   (w_n),
    .wb_vld(wb_vld),
    .q     (q),
    .q_vld (q_vld),
    .cq    (cq),
    .cq_n  (cq_n)
);

// File: tb/qb2_sram_tb.sv
module qb2_sram_tb;
    localparam int PERIOD = 10;
    localparam int DW = 36;
    localparam int AW = 4;
    localparam int NL = DW / 9;
    localparam int DEPTH = 1 << AW;

    logic k_clk = 1'b0;
    logic kn_clk, c_clk, cn_clk;
    logic tie = 1'b0;
    logic rst_n = 1'b0;
    logic r_n = 1'b1;
    logic w_n = 1'b1;
    logic [AW-1:0] sa = '0;
    logic [NL-1:0] bw_n = '1;
    logic [DW-1:0] d = '0;
    logic [DW-1:0] q;
    logic q_vld, cq, cq_n;

    assign kn_clk = ~k_clk;
    assign c_clk  = tie ? 1'b1 : k_clk;
    assign cn_clk = tie ? 1'b1 : kn_clk;

    always #(PERIOD/2) k_clk = ~k_clk;

    qb2_sram #(.DW(DW), .AW(AW)) u_dut (
        .k_clk(k_clk), .kn_clk(kn_clk), .c_clk(c_clk), .cn_clk(cn_clk),
        .rst_n(rst_n), .r_n(r_n), .w_n(w_n), .sa(sa), .bw_n(bw_n), .d(d),
        .q(q), .q_vld(q_vld), .cq(cq), .cq_n(cq_n)
    );

    typedef struct {
        int            due;
        logic [DW-1:0] w0;
        logic [DW-1:0] w1;
    } exp_t;

    exp_t          expq[$];
    logic [DW-1:0] ref_lo [DEPTH];
    logic [DW-1:0] ref_hi [DEPTH];
    int            cyc = 0;
    int            n_tests = 0;
    int            n_fail = 0;

    always @(posedge k_clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // driver: one cycle of stimulus, expected read burst pushed to the scoreboard
    task automatic tick(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                        input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                        input logic [NL-1:0] be0_n, input logic [NL-1:0] be1_n);
        exp_t e;
        @(posedge kn_clk); #2;
        r_n = !rd; w_n = !wr; sa = ra; d = w0; bw_n = be0_n;
        @(posedge k_clk); #2;
        r_n = 1'b1; w_n = 1'b1; sa = wa; d = w1; bw_n = be1_n;
        if (wr) begin
            for (int l = 0; l < NL; l++) begin
                if (!be0_n[l]) ref_lo[wa][l*9 +: 9] = w0[l*9 +: 9];
                if (!be1_n[l]) ref_hi[wa][l*9 +: 9] = w1[l*9 +: 9];
            end
        end
        if (rd) begin
            e.due = cyc + 1;
            e.w0  = ref_lo[ra];
            e.w1  = ref_hi[ra];
            expq.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0, '0, '0, '0, '1, '1);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // monitor: compares each half-cycle beat against the scoreboard
    initial begin
        exp_t cur;
        bit have;
        logic [DW-1:0] prev0, prev1;
        prev0 = '0; prev1 = '0;
        wait (rst_n);
        forever begin
            @(posedge kn_clk); #3;
            if (expq.size() > 0 && expq[0].due == cyc) begin
                cur  = expq.pop_front();
                have = 1'b1;
                chk(q_vld === 1'b1 && q === cur.w0, "R1 R5 R10 word0", q, cur.w0);
                chk(cq === 1'b0 && cq_n === 1'b1, "R8 echo beat0", {34'b0, cq, cq_n}, 36'b01);
                prev0 = q;
            end else begin
                have = 1'b0;
                chk(q_vld === 1'b0 && q === prev0, "R6 idle beat0", q, prev0);
            end
            @(posedge k_clk); #3;
            if (have) begin
                chk(q_vld === 1'b1 && q === cur.w1, "R1 R5 R10 word1", q, cur.w1);
                chk(cq === 1'b1 && cq_n === 1'b0, "R8 echo beat1", {34'b0, cq, cq_n}, 36'b10);
                prev1 = q;
            end else begin
                chk(q_vld === 1'b0 && q === prev1, "R6 idle beat1", q, prev1);
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin ref_lo[i] = '0; ref_hi[i] = '0; end
        repeat (3) @(posedge k_clk);
        #2;
        // R9
        chk(q_vld === 1'b0, "R9 reset valid", {35'b0, q_vld}, '0);
        chk(q === '0, "R9 reset data", q, '0);
        rst_n = 1'b1;
        idle(2);

        // R2 full writes, then R1 reads
        tick(1'b0, 0, 1'b1, 4'd3, 36'h123456789, 36'hABCDEF012, '0, '0);
        tick(1'b0, 0, 1'b1, 4'd5, 36'h0F0F0F0F0, 36'h5A5A5A5A5, '0, '0);
        tick(1'b1, 4'd3, 1'b0, 0, '0, '0, '1, '1);
        tick(1'b1, 4'd5, 1'b0, 0, '0, '0, '1, '1);
        idle(3);

        // R3 split lane patterns on each beat
        tick(1'b0, 0, 1'b1, 4'd3, 36'hFFFFFFFFF, 36'h000000000, 4'b1010, 4'b0101);
        idle(1);
        tick(1'b1, 4'd3, 1'b0, 0, '0, '0, '1, '1);
        idle(3);

        // R3 all lanes disabled, read in the next cycle
        tick(1'b0, 0, 1'b1, 4'd5, 36'h111111111, 36'h222222222, '1, '1);
        tick(1'b1, 4'd5, 1'b0, 0, '0, '0, '1, '1);
        idle(3);

        // R4 concurrent read and write to different slots
        tick(1'b1, 4'd5, 1'b1, 4'd7, 36'h777777777, 36'h888888888, '0, '0);
        tick(1'b1, 4'd7, 1'b0, 0, '0, '0, '1, '1);
        idle(3);

        // R5 same-cycle partial write and read of one slot, then next-cycle read
        tick(1'b1, 4'd7, 1'b1, 4'd7, 36'hCCCCCCCCC, 36'hDDDDDDDDD, 4'b0011, 4'b1100);
        tick(1'b1, 4'd7, 1'b0, 0, '0, '0, '1, '1);
        idle(3);

        // R10 back-to-back reads
        tick(1'b1, 4'd3, 1'b0, 0, '0, '0, '1, '1);
        tick(1'b1, 4'd5, 1'b0, 0, '0, '0, '1, '1);
        tick(1'b1, 4'd7, 1'b0, 0, '0, '0, '1, '1);
        tick(1'b1, 4'd3, 1'b0, 0, '0, '0, '1, '1);
        idle(4);

        // R7 output clocks parked high
        tie = 1'b1;
        idle(2);
        tick(1'b0, 0, 1'b1, 4'd9, 36'h314159265, 36'h271828182, '0, '0);
        tick(1'b1, 4'd9, 1'b1, 4'd2, 36'h0A0B0C0D0, 36'h102030405, '0, '0);
        tick(1'b1, 4'd2, 1'b0, 0, '0, '0, '1, '1);
        tick(1'b1, 4'd9, 1'b0, 0, '0, '0, '1, '1);
        idle(4);
        tie = 1'b0;
        idle(2);
        tick(1'b1, 4'd2, 1'b0, 0, '0, '0, '1, '1);
        idle(4);

        chk(expq.size() == 0, "R1 all bursts delivered", DW'(expq.size()), '0);
        summary();
        $finish;
    end
endmodule